// File: doc/BRIEF.md
# On-Chip Program Array Dump Controller

This block copies the whole one-time-programmable program array of a chip out through a 16-bit external write port, so that the array contents can be checked off-chip. It decides whether to run in the first cycle after reset. It runs only when the 4-bit mode selector carries the dump code and the external-fetch disable fuse is not blown. Before any array word leaves the chip, it reads a security key image from external memory and compares every word of it with the on-chip key. The lock bits play no part in this comparison. A single mismatched word parks the controller in a permanent loop, and nothing is written.

When the key matches, the controller reads the programming pulse-width word from external memory and presents it on an output. It then streams the array one word per external write, in ascending order. An active-low busy output stays low from the start of the key check until the last word has been written. For each write, the address and data are held for one cycle before and one cycle after a single-cycle strobe. A build-time switch selects the large-array variant. In that variant, the lower half of the array lands in one external word window and the upper half lands in a second window that begins at its own base.

Top module: `otp_dump_ctrl`

## Requirements
- R1: The controller starts only when `mode_sel` equals 4'h6 in the first cycle after reset. For any other value it performs no external read and no write, and `busy_n` stays high until the next reset.
- R2: When `dump_disable` is 1 in that first cycle, the dump is refused: no external read, no write, and `busy_n` stays high.
- R3: The key check reads the external key words one by one from word addresses 16'h0010 + i, for i from 0 to KEY_WORDS-1. Each word is compared with `key_int[16*i +: 16]`. If any word differs, the controller writes nothing and holds `busy_n` low until reset.
- R4: Once the key has matched, the controller reads external word address 16'h000A and presents that value on `pulse_width` before the first array write.
- R5: `busy_n` is low during every write and during the key check, and it goes high once the last array word has been written.
- R6: In the flat variant (SPLIT=0), each array word n is written exactly once, in ascending n. The write carries `ext_addr` = 16'h2000 + n and `ext_data` equal to the array word returned for `arr_rd_addr` = n.
- R7: In the split variant (SPLIT=1), word n below ARR_WORDS/2 goes to 16'h2000 + n, and each remaining word goes to 16'h5000 + (n - ARR_WORDS/2).
- R8: `ext_wr` is high for exactly one cycle per word. `ext_addr` and `ext_data` hold the same value in the cycle before the strobe, in the strobe cycle, and in the cycle after it.
- R9: After the last write, the controller stays idle until reset, with `ext_wr` low and `busy_n` high.
- R10: While `rst_n` is low, `busy_n` is high, `ext_wr` is low and `ext_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 4 | Mode selector, dump code 4'h6 |
| dump_disable | input | 1 | External-fetch disable fuse, 1 vetoes the dump |
| key_int | input | KEY_WORDS*16 | On-chip security key, word i at bits 16*i+15:16*i |
| ext_rd_en | output | 1 | External read request (key and pulse-width words) |
| ext_rd_addr | output | 16 | External read word address |
| ext_rd_data | input | 16 | External read data, valid the cycle after the request |
| arr_rd_addr | output | $clog2(ARR_WORDS) | Array word index |
| arr_rd_data | input | 16 | Array word, valid the cycle after the index |
| ext_wr | output | 1 | Single-cycle external write strobe, active high |
| ext_addr | output | 16 | External write word address |
| ext_data | output | 16 | External write data |
| busy_n | output | 1 | Active-low busy |
| pulse_width | output | 16 | Pulse-width word fetched after the key check |

## Verification
The assertions take `mode_sel` and `dump_disable` as static from reset release until the decision cycle. They also take the external and array read data to arrive exactly one cycle after the request. The bench meets both assumptions by setting the mode and fuse only while reset is held, and by modelling both memories as registered reads that answer every request on the next edge. Key mismatches are injected one word at a time, at the first and at the last key word, so that the comparison sequence is exercised at both ends.

// File: rtl/dump_pkg.sv
// Shared definitions for the array dump controller.
// Assumes: one controller per chip. The state encoding is internal to the block.
package dump_pkg;
    localparam logic [3:0] DUMP_MODE_CODE = 4'h6;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OFF,
        S_KEY_RD,
        S_KEY_CMP,
        S_LOCK,
        S_PPW_RD,
        S_PPW_CAP,
        S_ARR_RD,
        S_LOAD,
        S_SETUP,
        S_STROBE,
        S_HOLD,
        S_DONE
    } dump_state_e;
endpackage

// File: rtl/dump_addr_map.sv
// Maps an array word index to the external word address it is written to.
// Flat variant: one contiguous window from LO_BASE.
// Split variant: the lower half goes from LO_BASE and the upper half from HI_BASE.
// Assumes: ARR_WORDS is even when SPLIT is set. The result fits in 16 bits.
module dump_addr_map #(
    parameter int          ARR_WORDS = 32,
    parameter bit          SPLIT     = 1'b0,
    parameter logic [15:0] LO_BASE   = 16'h2000,
    parameter logic [15:0] HI_BASE   = 16'h5000,
    localparam int         IDX_W     = $clog2(ARR_WORDS)
) (
    input  logic [IDX_W-1:0] word_idx,
    output logic [15:0]      ext_word_addr
);
    localparam int HALF = ARR_WORDS / 2;

    generate
        if (SPLIT) begin : g_split
            // Pick the window by half and rebase the index into it.
            always_comb begin
                if (int'(word_idx) < HALF)
                    ext_word_addr = LO_BASE + 16'(word_idx);
                else
                    ext_word_addr = HI_BASE + 16'(int'(word_idx) - HALF);
            end
        end else begin : g_flat
            // One window: base plus index.
            assign ext_word_addr = LO_BASE + 16'(word_idx);
        end
    endgenerate
endmodule

// File: rtl/dump_key_cmp.sv
// Compares one external key word with the matching word of the on-chip key.
// Assumes: key_sel is below KEY_WORDS. Word i sits at bits 16*i+15:16*i.
module dump_key_cmp #(
    parameter int  KEY_WORDS = 8,
    localparam int KSEL_W    = $clog2(KEY_WORDS)
) (
    input  logic [KEY_WORDS*16-1:0] key_ref,
    input  logic [KSEL_W-1:0]       key_sel,
    input  logic [15:0]             key_ext,
    output logic                    key_ok
);
    // Equality of the selected on-chip word with the external word.
    assign key_ok = (key_ref[{key_sel, 4'b0000} +: 16] == key_ext);
endmodule

// File: rtl/otp_dump_ctrl.sv
// Array dump controller, top level.
// Decides once after reset whether to dump. Checks the external key image word
// by word, fetches the pulse-width word, then writes every array word out with
// one cycle of setup and one cycle of hold around a one-cycle strobe.
// Assumes: mode_sel and dump_disable are static from reset release. External
// and array reads return data one cycle after the request.
module otp_dump_ctrl #(
    parameter int          ARR_WORDS = 32,
    parameter bit          SPLIT     = 1'b0,
    parameter logic [15:0] LO_BASE   = 16'h2000,
    parameter logic [15:0] HI_BASE   = 16'h5000,
    parameter int          KEY_WORDS = 8,
    parameter logic [15:0] KEY_BASE  = 16'h0010,
    parameter logic [15:0] PPW_ADDR  = 16'h000A,
    localparam int         IDX_W     = $clog2(ARR_WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [3:0]              mode_sel,
    input  logic                    dump_disable,
    input  logic [KEY_WORDS*16-1:0] key_int,
    output logic                    ext_rd_en,
    output logic [15:0]             ext_rd_addr,
    input  logic [15:0]             ext_rd_data,
    output logic [IDX_W-1:0]        arr_rd_addr,
    input  logic [15:0]             arr_rd_data,
    output logic                    ext_wr,
    output logic [15:0]             ext_addr,
    output logic [15:0]             ext_data,
    output logic                    busy_n,
    output logic [15:0]             pulse_width
);
    import dump_pkg::*;

    localparam int               KSEL_W   = $clog2(KEY_WORDS);
    localparam logic [KSEL_W-1:0] KEY_LAST = KSEL_W'(KEY_WORDS - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(ARR_WORDS - 1);

    dump_state_e       st;
    logic [KSEL_W-1:0] kidx;
    logic [IDX_W-1:0]  widx;
    logic              key_ok;
    logic [15:0]       mapped_addr;

    dump_key_cmp #(.KEY_WORDS(KEY_WORDS)) key_cmp_i (
        .key_ref (key_int),
        .key_sel (kidx),
        .key_ext (ext_rd_data),
        .key_ok  (key_ok)
    );

    dump_addr_map #(
        .ARR_WORDS (ARR_WORDS),
        .SPLIT     (SPLIT),
        .LO_BASE   (LO_BASE),
        .HI_BASE   (HI_BASE)
    ) addr_map_i (
        .word_idx      (widx),
        .ext_word_addr (mapped_addr)
    );

    // Sequencer: entry decision, key loop, pulse-width fetch, word stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            kidx        <= '0;
            widx        <= '0;
            pulse_width <= '0;
            ext_addr    <= '0;
            ext_data    <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    kidx <= '0;
                    st   <= (mode_sel == DUMP_MODE_CODE && !dump_disable) ? S_KEY_RD : S_OFF;
                end
                S_KEY_RD:  st <= S_KEY_CMP;
                S_KEY_CMP: begin
                    if (!key_ok)
                        st <= S_LOCK;
                    else if (kidx == KEY_LAST)
                        st <= S_PPW_RD;
                    else begin
                        kidx <= kidx + 1'b1;
                        st   <= S_KEY_RD;
                    end
                end
                S_PPW_RD:  st <= S_PPW_CAP;
                S_PPW_CAP: begin
                    pulse_width <= ext_rd_data;
                    widx        <= '0;
                    st          <= S_ARR_RD;
                end
                S_ARR_RD:  st <= S_LOAD;
                S_LOAD: begin
                    ext_addr <= mapped_addr;
                    ext_data <= arr_rd_data;
                    st       <= S_SETUP;
                end
                S_SETUP:   st <= S_STROBE;
                S_STROBE:  st <= S_HOLD;
                S_HOLD: begin
                    if (widx == IDX_LAST)
                        st <= S_DONE;
                    else begin
                        widx <= widx + 1'b1;
                        st   <= S_ARR_RD;
                    end
                end
                default:   st <= st;
            endcase
        end
    end

    // External read requests: key words first, then the pulse-width word.
    always_comb begin
        ext_rd_en   = (st == S_KEY_RD) || (st == S_PPW_RD);
        ext_rd_addr = (st == S_PPW_RD) ? PPW_ADDR : KEY_BASE + 16'(kidx);
    end

    // Array index, write strobe and active-low busy, all decoded from state.
    always_comb begin
        arr_rd_addr = widx;
        ext_wr      = (st == S_STROBE);
        busy_n      = (st == S_IDLE) || (st == S_OFF) || (st == S_DONE);
    end

    // R1: a code other than the dump code leads straight to the off state.
    a_r1_wrong_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && mode_sel != DUMP_MODE_CODE) |=> (st == S_OFF));

    // R2: the disable fuse vetoes the dump.
    a_r2_fuse_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && dump_disable) |=> (st == S_OFF));

    // R3: a key mismatch locks the controller for good, with no write.
    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_LOCK) |=> (st == S_LOCK && !ext_wr && !busy_n));

    // R5: busy_n is low whenever a word is written.
    a_r5_busy_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr |-> !busy_n);

    // R8: the strobe lasts one cycle.
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr |=> !ext_wr);

    // R8: address and data are set up one cycle before the strobe.
    a_r8_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_wr) |-> ($stable(ext_addr) && $stable(ext_data)));

    // R8: address and data are held one cycle after the strobe.
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_wr) |-> ($stable(ext_addr) && $stable(ext_data)));

    // R9: once finished, the controller stays idle with busy released.
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DONE) |=> (st == S_DONE && busy_n && !ext_wr));
endmodule

// File: tb/otp_dump_ctrl_tb_top.sv
// Bench: a flat instance and a split instance share mode, fuse and key.
// Registered memory models answer their reads.
module otp_dump_ctrl_tb_top;
    localparam int W   = 32;
    localparam int WS  = 16;
    localparam int KW  = 8;
    localparam int NV  = 6;

    // Vector fields: [15:12] mode, [11] fuse, [10] bad key, [9:7] bad word,
    // [6] dump expected, [5] final busy_n expected.
    localparam logic [15:0] VEC [0:NV-1] = '{
        {4'h6, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 5'd0},
        {4'h6, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 5'd0},
        {4'h5, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 5'd0},
        {4'h6, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 5'd0},
        {4'h6, 1'b0, 1'b1, 3'd7, 1'b0, 1'b0, 5'd0},
        {4'hE, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 5'd0}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n;
    logic [3:0]       mode_sel;
    logic             dump_disable;
    logic [KW*16-1:0] key_int;
    logic [15:0]      ext_mem [0:63];

    logic        a_rd_en, b_rd_en, a_wr, b_wr, a_busy, b_busy;
    logic [15:0] a_rd_addr, b_rd_addr, a_rd_data, b_rd_data;
    logic [4:0]  a_arr_addr;
    logic [3:0]  b_arr_addr;
    logic [15:0] a_arr_data, b_arr_data, a_addr, b_addr, a_data, b_data, a_ppw, b_ppw;

    otp_dump_ctrl #(.ARR_WORDS(W), .SPLIT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dump_disable(dump_disable),
        .key_int(key_int), .ext_rd_en(a_rd_en), .ext_rd_addr(a_rd_addr),
        .ext_rd_data(a_rd_data), .arr_rd_addr(a_arr_addr), .arr_rd_data(a_arr_data),
        .ext_wr(a_wr), .ext_addr(a_addr), .ext_data(a_data), .busy_n(a_busy),
        .pulse_width(a_ppw));

    otp_dump_ctrl #(.ARR_WORDS(WS), .SPLIT(1'b1)) dut_split_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dump_disable(dump_disable),
        .key_int(key_int), .ext_rd_en(b_rd_en), .ext_rd_addr(b_rd_addr),
        .ext_rd_data(b_rd_data), .arr_rd_addr(b_arr_addr), .arr_rd_data(b_arr_data),
        .ext_wr(b_wr), .ext_addr(b_addr), .ext_data(b_data), .busy_n(b_busy),
        .pulse_width(b_ppw));

    function automatic logic [15:0] arr_val(input logic [15:0] a);
        return 16'h5A00 ^ (a * 16'd257);
    endfunction

    function automatic logic [15:0] key_word(input int i);
        return 16'h7100 + 16'(i) * 16'h0013;
    endfunction

    // Registered memory models: data arrives one cycle after the request.
    always @(posedge clk) begin
        if (a_rd_en) a_rd_data <= ext_mem[a_rd_addr[5:0]];
        if (b_rd_en) b_rd_data <= ext_mem[b_rd_addr[5:0]];
        a_arr_data <= arr_val(16'(a_arr_addr));
        b_arr_data <= arr_val(16'(b_arr_addr));
    end

    int checks = 0, errors = 0, cyc = 0;
    int a_wn, b_wn, a_rn, b_rn, a_busybad, b_busybad, tim_bad;
    logic [15:0] a_la [0:63], a_ld [0:63], b_la [0:63], b_ld [0:63];
    logic [15:0] pa_addr, pa_data, pb_addr, pb_data;
    logic        pa_wr, pb_wr;

    // Monitor away from the edge: log writes, count reads, check setup and hold.
    always @(negedge clk) begin
        if (a_wr) begin
            if (a_wn < 64) begin a_la[a_wn] = a_addr; a_ld[a_wn] = a_data; end
            a_wn++;
            if (a_busy) a_busybad++;
            if (a_addr != pa_addr || a_data != pa_data || pa_wr) tim_bad++;
        end
        if (pa_wr && !a_wr && (a_addr != pa_addr || a_data != pa_data)) tim_bad++;
        if (b_wr) begin
            if (b_wn < 64) begin b_la[b_wn] = b_addr; b_ld[b_wn] = b_data; end
            b_wn++;
            if (b_busy) b_busybad++;
            if (b_addr != pb_addr || b_data != pb_data || pb_wr) tim_bad++;
        end
        if (pb_wr && !b_wr && (b_addr != pb_addr || b_data != pb_data)) tim_bad++;
        if (a_rd_en) a_rn++;
        if (b_rd_en) b_rn++;
        pa_addr = a_addr; pa_data = a_data; pa_wr = a_wr;
        pb_addr = b_addr; pb_data = b_data; pb_wr = b_wr;
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic clear_logs();
        a_wn = 0; b_wn = 0; a_rn = 0; b_rn = 0;
        a_busybad = 0; b_busybad = 0; tim_bad = 0;
    endtask

    task automatic fill_mem(input bit bad, input int bad_idx, input logic [15:0] ppw);
        for (int i = 0; i < 64; i++) ext_mem[i] = 16'hFFFF;
        ext_mem[10] = ppw;
        for (int k = 0; k < KW; k++) ext_mem[16 + k] = key_word(k);
        if (bad) ext_mem[16 + bad_idx] = ext_mem[16 + bad_idx] ^ 16'h0040;
    endtask

    task automatic start_run(input logic [3:0] m, input bit dis);
        mode_sel = m; dump_disable = dis; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        clear_logs();
        chk(a_busy === 1'b1 && a_wr === 1'b0 && a_rd_en === 1'b0,
            "R10 reset state busy/wr/rd", {a_busy, a_wr, a_rd_en}, 3'b100);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < KW; i++) key_int[i*16 +: 16] = key_word(i);
        pa_wr = 1'b0; pb_wr = 1'b0; pa_addr = '0; pa_data = '0; pb_addr = '0; pb_data = '0;

        for (int v = 0; v < NV; v++) begin
            automatic logic [15:0] e   = VEC[v];
            automatic bit          exp_dump = e[6];
            automatic logic [15:0] ppw = 16'h1230 + 16'(v);
            automatic string       req;
            if (exp_dump)          req = "R6";
            else if (e[11])        req = "R2";
            else if (e[15:12] != 4'h6) req = "R1";
            else                   req = "R3";
            fill_mem(e[10], int'(e[9:7]), ppw);
            start_run(e[15:12], e[11]);
            repeat (400) @(negedge clk);
            chk(a_wn == (exp_dump ? W : 0), {req, " flat write count"}, a_wn, exp_dump ? W : 0);
            chk(b_wn == (exp_dump ? WS : 0), {req, " split write count"}, b_wn, exp_dump ? WS : 0);
            chk(a_busy == e[5], {req, " R5 final busy_n"}, a_busy, e[5]);
            if (exp_dump) begin
                chk(a_ppw == ppw && b_ppw == ppw, "R4 pulse width", a_ppw, ppw);
                chk(a_busybad == 0 && b_busybad == 0, "R5 busy low while writing", a_busybad, 0);
                chk(tim_bad == 0, "R8 setup/hold/single strobe", tim_bad, 0);
                for (int n = 0; n < W; n++)
                    chk(a_la[n] == 16'h2000 + 16'(n) && a_ld[n] == arr_val(16'(n)),
                        "R6 flat address/data", a_la[n], 16'h2000 + 16'(n));
                for (int n = 0; n < WS; n++) begin
                    automatic logic [15:0] ea = (n < WS/2) ? 16'h2000 + 16'(n)
                                                           : 16'h5000 + 16'(n - WS/2);
                    chk(b_la[n] == ea && b_ld[n] == arr_val(16'(n)),
                        "R7 split address/data", b_la[n], ea);
                end
                repeat (50) @(negedge clk);
                chk(a_wn == W && b_wn == WS && a_busy && b_busy && !a_wr,
                    "R9 idle after completion", a_wn, W);
            end else if (e[11] || e[15:12] != 4'h6) begin
                chk(a_rn == 0 && b_rn == 0, {req, " no external reads"}, a_rn, 0);
            end else begin
                chk(a_rn == int'(e[9:7]) + 1, "R3 key reads up to mismatch", a_rn, int'(e[9:7]) + 1);
            end
        end

        // Directed: busy low in mid-dump, then reset during the dump.
        fill_mem(1'b0, 0, 16'h0BEE);
        start_run(4'h6, 1'b0);
        repeat (60) @(negedge clk);
        chk(a_busy == 1'b0 && a_wn > 0 && a_wn < W, "R5 busy low mid-dump", a_busy, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(a_busy == 1'b1 && a_wr == 1'b0, "R10 reset mid-dump", a_busy, 1);
        start_run(4'h7, 1'b0);
        repeat (300) @(negedge clk);
        chk(a_wn == 0 && a_rn == 0 && a_busy, "R1 code 7 after reset idle", a_wn, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule